// File: doc/BRIEF.md
# Inbound Bus Address Window Decoder

This block sits on the slave side of a backplane interface and decides, one request per cycle, whether an incoming bus address falls into one of the local inbound windows. There are three windows, one per address space. The wide window is in the 32-bit space and the mid window is in the 24-bit space; both serve DMA traffic. The small window is a 256-byte slot in the 16-bit space and serves interprocessor messages. Each request carries an address, a two-bit space tag and a valid strobe. The block answers one cycle later with a hit flag, a one-hot window select and the byte offset inside the selected window.

The window bases and sizes are held in registers that a simple write port loads. Sizes are programmed as log2 codes. A base that is not a multiple of its window size is not rejected. The block uses it rounded down to the nearest legal boundary. A mode flag chooses how the 24-bit space relates to the bottom 16 MB of the 32-bit space. In separate mode the two spaces are independent. In shared mode the two spaces are treated as one region.

Top module: `inbound_window_decoder`

## Requirements
- R1: After reset the wide window has base 0x08000000 and size 128 MB. The mid window has base 0x00C00000 and size 4 MB. The small window base is 0x0100. The mode flag is 1 (separate). All outputs are zero.
- R2: A size code n (4 bits) selects a span of 64 KB shifted left by n. For the wide window, codes above 11 act as 11 (128 MB). For the mid window, codes above 8 act as 8 (16 MB).
- R3: The decoder uses each base rounded down to a multiple of its window size. For the small window this is a 256-byte boundary, so only base bits 15:8 count.
- R4: A request with tag 2 (32-bit space) hits the wide window when its address, with the low log2(size) bits cleared, equals the rounded wide base. The offset is the address bits below the size.
- R5: A request with tag 1 (24-bit space) is compared against the mid window using address bits 23:0 only. Bits 31:24 are ignored.
- R6: A request with tag 0 (16-bit space) hits the small window when address bits 15:8 match the base. The offset is address bits 7:0. Bits 31:16 are ignored.
- R7: Outputs are registered: a request presented in one cycle is answered after the next rising edge. win_sel is one-hot: bit 0 is small, bit 1 is mid, bit 2 is wide. hit is high exactly when one select bit is set.
- R8: A miss, a cycle with req_valid low, or tag 3 all give hit low, win_sel zero and offset zero.
- R9: When the mode flag is 1, a tag 2 request never hits the mid window and a tag 1 request never hits the wide window. This holds even when the two addresses are numerically equal.
- R10: Shared mode applies when the mode flag is 0 and the rounded wide base is zero. In shared mode, a tag 2 request below 0x01000000 does not hit the wide window. It is instead decoded against the mid window using bits 23:0.
- R11: A write on the register port takes effect for requests presented from the cycle after the write. The write uses cfg_addr 0 for the wide base, 1 for the wide size code, 2 for the mid base (bits 23:0), 3 for the mid size code, 4 for the small base (bits 15:0) and 5 for the mode flag (bit 0). Writes to cfg_addr 6 and 7 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select |
| cfg_wdata | input | 32 | Register write data |
| req_valid | input | 1 | Request strobe |
| req_space | input | 2 | Address space tag: 0 16-bit, 1 24-bit, 2 32-bit, 3 none |
| req_addr | input | 32 | Bus address |
| hit | output | 1 | Registered window hit |
| win_sel | output | 3 | Registered one-hot window select |
| offset | output | 32 | Registered offset inside the window |

## Verification
The bound checker covers the properties that hold on every cycle:
- win_sel is one-hot and agrees with hit.
- offset is zero on a miss.
- An idle cycle or tag 3 gives no hit.
- A tag never selects a window of a wider space than its own in separate mode.
- Offsets stay inside the small and mid spans.

Only the bench scenarios can show the values that depend on the register contents. These are the base rounding, the size saturation, exact window edges, the shared-mode redirection below 16 MB, and the timing of a write that lands in the same cycle as a request.

// File: rtl/inbound_window_decoder.sv
module inbound_window_decoder #(
  parameter int          AW        = 32,
  parameter int          MAW       = 24,
  parameter int          SAW       = 16,
  parameter int          SLOT_BITS = 8,
  parameter int          MIN_BITS  = 16,
  parameter int          CODE_W    = 4,
  parameter int          W_MAXCODE = 11,
  parameter logic [AW-1:0]  W_BASE_RST = 32'h0800_0000,
  parameter logic [CODE_W-1:0] W_CODE_RST = 4'd11,
  parameter logic [MAW-1:0] M_BASE_RST = 24'hC0_0000,
  parameter logic [CODE_W-1:0] M_CODE_RST = 4'd6,
  parameter logic [SAW-1:0] S_BASE_RST = 16'h0100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_addr,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          req_valid,
  input  logic [1:0]    req_space,
  input  logic [AW-1:0] req_addr,
  output logic          hit,
  output logic [2:0]    win_sel,
  output logic [AW-1:0] offset
);

  localparam int M_MAXCODE = MAW - MIN_BITS;
  localparam logic [1:0] SP_SMALL = 2'd0;
  localparam logic [1:0] SP_MID   = 2'd1;
  localparam logic [1:0] SP_WIDE  = 2'd2;

  logic [AW-1:0]     wbase_q;
  logic [CODE_W-1:0] wcode_q;
  logic [MAW-1:0]    mbase_q;
  logic [CODE_W-1:0] mcode_q;
  logic [SAW-1:0]    sbase_q;
  logic              sep_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbase_q <= W_BASE_RST;
      wcode_q <= W_CODE_RST;
      mbase_q <= M_BASE_RST;
      mcode_q <= M_CODE_RST;
      sbase_q <= S_BASE_RST;
      sep_q   <= 1'b1;
    end else if (cfg_we) begin
      case (cfg_addr)
        3'd0: wbase_q <= cfg_wdata;
        3'd1: wcode_q <= cfg_wdata[CODE_W-1:0];
        3'd2: mbase_q <= cfg_wdata[MAW-1:0];
        3'd3: mcode_q <= cfg_wdata[CODE_W-1:0];
        3'd4: sbase_q <= cfg_wdata[SAW-1:0];
        3'd5: sep_q   <= cfg_wdata[0];
        default: ;
      endcase
    end
  end

  logic [CODE_W-1:0] wcode_eff, mcode_eff;
  logic [AW:0]       wspan;
  logic [MAW:0]      mspan;
  logic [AW-1:0]     wmask, wbase_eff;
  logic [MAW-1:0]    mmask, mbase_eff;

  assign wcode_eff = (wcode_q > CODE_W'(W_MAXCODE)) ? CODE_W'(W_MAXCODE) : wcode_q;
  assign mcode_eff = (mcode_q > CODE_W'(M_MAXCODE)) ? CODE_W'(M_MAXCODE) : mcode_q;
  assign wspan     = (AW+1)'(1) << (MIN_BITS + int'(wcode_eff));
  assign mspan     = (MAW+1)'(1) << (MIN_BITS + int'(mcode_eff));
  assign wmask     = wspan[AW-1:0] - AW'(1);
  assign mmask     = mspan[MAW-1:0] - MAW'(1);
  assign wbase_eff = wbase_q & ~wmask;
  assign mbase_eff = mbase_q & ~mmask;

  logic shared, low_region;
  logic w_hit, m_hit, s_hit, m_space;
  logic [MAW-1:0] maddr;

  assign shared     = !sep_q && (wbase_eff == '0);
  assign low_region = (req_addr[AW-1:MAW] == '0);
  assign maddr      = req_addr[MAW-1:0];
  assign m_space    = (req_space == SP_MID) || (req_space == SP_WIDE && shared && low_region);

  assign w_hit = req_valid && req_space == SP_WIDE && !(shared && low_region)
                 && ((req_addr & ~wmask) == wbase_eff);
  assign m_hit = req_valid && m_space && ((maddr & ~mmask) == mbase_eff);
  assign s_hit = req_valid && req_space == SP_SMALL
                 && (req_addr[SAW-1:SLOT_BITS] == sbase_q[SAW-1:SLOT_BITS]);

  logic [AW-1:0] off_d;
  always_comb begin
    off_d = '0;
    if (w_hit)      off_d = req_addr & wmask;
    else if (m_hit) off_d = AW'(maddr & mmask);
    else if (s_hit) off_d = AW'(req_addr[SLOT_BITS-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit     <= 1'b0;
      win_sel <= '0;
      offset  <= '0;
    end else begin
      hit     <= w_hit | m_hit | s_hit;
      win_sel <= {w_hit, m_hit, s_hit};
      offset  <= off_d;
    end
  end

endmodule

// File: rtl/inbound_window_decoder_checks.sv
module inbound_window_decoder_checks (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [1:0]  req_space,
  input logic        hit,
  input logic [2:0]  win_sel,
  input logic [31:0] offset,
  input logic        sep_q
);

  p_sel_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_sel) && (hit == (win_sel != 3'b000)));

  p_miss_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> offset == 32'd0);

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid || req_space == 2'd3) |=> !hit);

  p_mid_never_wide_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_space == 2'd1) |=> !win_sel[2]);

  p_wide_never_mid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_space == 2'd2 && sep_q) |=> !win_sel[1]);

  p_small_only_small_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_space == 2'd0) |=> (win_sel[2:1] == 2'b00));

  p_small_offset_r6: assert property (@(posedge clk) disable iff (!rst_n)
    win_sel[0] |-> offset[31:8] == 24'd0);

  p_mid_offset_r5: assert property (@(posedge clk) disable iff (!rst_n)
    win_sel[1] |-> offset[31:24] == 8'd0);

endmodule

bind inbound_window_decoder inbound_window_decoder_checks u_checks (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_space(req_space),
  .hit(hit), .win_sel(win_sel), .offset(offset), .sep_q(sep_q)
);

// File: tb/test_inbound_window_decoder.sv
`timescale 1ns/1ps
module test_inbound_window_decoder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_space = '0;
  logic [31:0] req_addr = '0;
  logic        hit;
  logic [2:0]  win_sel;
  logic [31:0] offset;

  always #4 clk = ~clk;

  inbound_window_decoder i_inbound_window_decoder (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_space(req_space),
    .req_addr(req_addr), .hit(hit), .win_sel(win_sel), .offset(offset)
  );

  typedef struct {
    logic        h;
    logic [2:0]  s;
    logic [31:0] o;
    string       tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  localparam logic [2:0] SM = 3'b001, MD = 3'b010, WD = 3'b100, NO = 3'b000;

  task automatic compare(input exp_t e);
    checks++;
    if (hit !== e.h || win_sel !== e.s || offset !== e.o) begin
      fails++;
      $display("FAIL %s: got hit=%0b sel=%03b off=%08h, expected hit=%0b sel=%03b off=%08h",
               e.tag, hit, win_sel, offset, e.h, e.s, e.o);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (q.size() > 0) compare(q.pop_front());
  end

  task automatic drive(input logic we, input logic [2:0] ca, input logic [31:0] cd,
                       input logic v, input logic [1:0] sp, input logic [31:0] a,
                       input logic [2:0] es, input logic [31:0] eo, input string tag);
    exp_t e;
    @(negedge clk);
    cfg_we = we; cfg_addr = ca; cfg_wdata = cd;
    req_valid = v; req_space = sp; req_addr = a;
    e.h = (es != 3'b000); e.s = es; e.o = eo; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic req(input logic [1:0] sp, input logic [31:0] a,
                     input logic [2:0] es, input logic [31:0] eo, input string tag);
    drive(1'b0, 3'd0, 32'd0, 1'b1, sp, a, es, eo, tag);
  endtask

  task automatic wr(input logic [2:0] ca, input logic [31:0] cd);
    drive(1'b1, ca, cd, 1'b0, 2'd0, 32'd0, NO, 32'd0, "R11 write cycle quiet");
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (hit !== 1'b0 || win_sel !== 3'b000 || offset !== 32'd0) begin
      fails++;
      $display("FAIL R1 reset outputs: got %0b %03b %08h, expected 0 000 00000000", hit, win_sel, offset);
    end
    rst_n = 1'b1;

    drive(1'b0, 3'd0, 32'd0, 1'b0, 2'd2, 32'h0800_0000, NO, 32'd0, "R1 R8 idle after reset");
    // R1 R4 default wide window
    req(2'd2, 32'h0800_0010, WD, 32'h0000_0010, "R1 R4 wide low");
    req(2'd2, 32'h0FFF_FFFF, WD, 32'h07FF_FFFF, "R4 wide top edge");
    req(2'd2, 32'h1000_0000, NO, 32'd0, "R4 wide above");
    req(2'd2, 32'h07FF_FFFF, NO, 32'd0, "R4 wide below");
    // R1 R5 default mid window
    req(2'd1, 32'h00C0_0004, MD, 32'h0000_0004, "R1 R5 mid hit");
    req(2'd1, 32'hFFC0_0004, MD, 32'h0000_0004, "R5 mid upper bits ignored");
    req(2'd1, 32'h00BF_FFFF, NO, 32'd0, "R5 mid below");
    // R1 R6 default small window
    req(2'd0, 32'h0000_0100, SM, 32'h0, "R1 R6 small base");
    req(2'd0, 32'h0000_01FF, SM, 32'hFF, "R6 small top");
    req(2'd0, 32'h0000_0200, NO, 32'd0, "R6 small above");
    req(2'd0, 32'h0000_00FF, NO, 32'd0, "R6 small below");
    req(2'd0, 32'hABCD_0142, SM, 32'h42, "R6 small upper bits ignored");
    // R8
    req(2'd3, 32'h0800_0000, NO, 32'd0, "R8 tag 3");
    drive(1'b0, 3'd0, 32'd0, 1'b0, 2'd2, 32'h0800_0004, NO, 32'd0, "R8 valid low");
    // R9 separate mode with wide base zero
    wr(3'd0, 32'h0);
    req(2'd2, 32'h00C0_0000, WD, 32'h00C0_0000, "R9 wide tag stays wide");
    req(2'd1, 32'h00C0_0000, MD, 32'h0, "R9 mid tag stays mid");
    // R10 shared mode
    wr(3'd5, 32'h0);
    req(2'd2, 32'h00C0_0000, MD, 32'h0, "R10 low wide address to mid window");
    req(2'd2, 32'h0010_0000, NO, 32'd0, "R10 low wide address outside mid window");
    req(2'd2, 32'h0100_0010, WD, 32'h0100_0010, "R10 wide above 16MB");
    req(2'd2, 32'h07FF_FFFF, WD, 32'h07FF_FFFF, "R10 wide top");
    wr(3'd5, 32'h1);
    // R3 rounding
    wr(3'd0, 32'h0A34_5678);
    req(2'd2, 32'h0800_0000, WD, 32'h0, "R3 base rounded to 128MB");
    wr(3'd1, 32'd3);
    req(2'd2, 32'h0A30_0000, WD, 32'h0, "R2 R3 512KB base");
    req(2'd2, 32'h0A37_FFFF, WD, 32'h0007_FFFF, "R3 512KB top");
    req(2'd2, 32'h0A38_0000, NO, 32'd0, "R3 512KB above");
    req(2'd2, 32'h0A2F_FFFF, NO, 32'd0, "R3 512KB below");
    // R2 saturation
    wr(3'd1, 32'd15);
    req(2'd2, 32'h0FFF_FFFF, WD, 32'h07FF_FFFF, "R2 wide code saturates");
    req(2'd2, 32'h1000_0000, NO, 32'd0, "R2 wide saturated above");
    wr(3'd2, 32'h00AB_CDEF);
    wr(3'd3, 32'd12);
    req(2'd1, 32'h0000_0005, MD, 32'h5, "R2 mid code saturates low");
    req(2'd1, 32'h00FF_FFFF, MD, 32'h00FF_FFFF, "R2 mid saturated top");
    wr(3'd2, 32'h0012_3456);
    wr(3'd3, 32'd0);
    req(2'd1, 32'h0012_FFFF, MD, 32'h0000_FFFF, "R2 R3 mid 64KB top");
    req(2'd1, 32'h0013_0000, NO, 32'd0, "R3 mid 64KB above");
    req(2'd1, 32'h0011_FFFF, NO, 32'd0, "R3 mid 64KB below");
    // small base rounding
    wr(3'd4, 32'h0001_2345);
    req(2'd0, 32'h0000_2345, SM, 32'h45, "R3 small base slot");
    req(2'd0, 32'h0000_2400, NO, 32'd0, "R3 small next slot");
    // R11 ignored address and write timing
    wr(3'd6, 32'h0);
    wr(3'd7, 32'hFFFF_FFFF);
    req(2'd0, 32'h0000_2345, SM, 32'h45, "R11 unused address ignored");
    req(2'd2, 32'h0800_0004, WD, 32'h4, "R11 unused address leaves wide");
    drive(1'b1, 3'd4, 32'h0000_4000, 1'b1, 2'd0, 32'h0000_2345, SM, 32'h45, "R11 same-cycle uses old base");
    req(2'd0, 32'h0000_4010, SM, 32'h10, "R11 new base active");
    req(2'd0, 32'h0000_2345, NO, 32'd0, "R11 old base gone");
    drive(1'b0, 3'd0, 32'd0, 1'b0, 2'd0, 32'd0, NO, 32'd0, "R8 final idle");

    repeat (3) @(posedge clk);
    #3;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule